// File: doc/BRIEF.md
# Dual-Timing Host Bus Front End

This block sits between a multiplexed host bus and the register file of a small peripheral, such as a timekeeper with battery-backed storage. A static strap picks the bus timing. With the strap high, the host uses a data strobe and a read/write level. With the strap low, the host drives two separate active-low strobes: one for reads and one for writes. The block brings every bus input into the internal clock domain. It latches the register address from the shared address/data lines when the address strobe falls. It then turns each host access into internal strobes of one clock each.

An access counts only if chip select (active low) is held for the whole strobe phase, the power-fail input is low, and the host reset input is high. An address-strobe edge always updates the latched address, even if the cycle that follows is not qualified. During a qualified read, the register read data is driven onto the bus output and an output enable is raised. At all other times the output enable is low and the data output is zero.

Top module: `mbus_front`

## Requirements
- R1: While `rst` is high, and on the clock after it is released, `reg_addr_o`, `reg_wr_o`, `reg_rd_o`, `ad_oe_o` and `ad_o` are all zero.
- R2: A falling edge of `as_i` loads the low AW bits of `ad_i` into `reg_addr_o`. This happens whatever the state of chip select, power-fail and host reset. Upper `ad_i` bits are dropped. Between such edges `reg_addr_o` holds its value.
- R3: With `mode_strap_i` high, a cycle where `ds_i` is high and `rw_i` is high is a read phase. A cycle where `ds_i` is high and `rw_i` is low is a write phase.
- R4: With `mode_strap_i` low, `rw_i` low is a write phase. `ds_i` low with `rw_i` high is a read phase.
- R5: A qualified write phase gives exactly one `reg_wr_o` pulse of one clock, one clock after the phase ends. During that pulse, `reg_wdata_o` equals `ad_i` as sampled in the last cycle of the phase.
- R6: A qualified read phase gives one `reg_rd_o` pulse of one clock at its start. `ad_oe_o` is high for every qualified cycle of the phase, and during that time `ad_o` equals `reg_rdata_i`. At all other times `ad_oe_o` is 0 and `ad_o` is 0.
- R7: If `cs_n_i` is high during any cycle of a strobe phase, that access produces no write pulse. It also drops the read output enable from that cycle to the end of the phase.
- R8: While `pwr_fail_i` is high, no access is qualified.
- R9: While `host_rst_n_i` is low, no access is qualified.
- R10: With the default two synchronizer stages, a change on the bus inputs first shows on the registered outputs after the third rising clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap_i | input | 1 | 1: data strobe with read/write level; 0: separate active-low strobes |
| cs_n_i | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe; falling edge latches the address |
| ds_i | input | 1 | Data strobe (strap high) or read strobe, active low (strap low) |
| rw_i | input | 1 | Read/write level (strap high) or write strobe, active low (strap low) |
| pwr_fail_i | input | 1 | Power-fail indication, high inhibits access |
| host_rst_n_i | input | 1 | Host reset, low inhibits access |
| ad_i | input | DW | Multiplexed address/data bus input |
| ad_o | output | DW | Read data toward the bus, zero when not enabled |
| ad_oe_o | output | 1 | Bus output enable |
| reg_addr_o | output | AW | Latched register address |
| reg_wr_o | output | 1 | One-clock register write strobe |
| reg_wdata_o | output | DW | Register write data |
| reg_rd_o | output | 1 | One-clock register read strobe |
| reg_rdata_i | input | DW | Register read data |

## Verification
The bench builds the block with AW=6, DW=8 and two synchronizer stages. Because AW is narrower than DW, the bench can drive addresses with upper bits set and check that they are dropped from the latched address. With two stages, the bench model follows the exact three-edge latency and the one-clock-late write strobe. It also reaches the case where a chip-select glitch in the middle of a phase cancels a write, and the case where the strap changes between cycles.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Control lines of the host bus, in sampled form
    typedef struct packed {
        logic mode;
        logic cs_n;
        logic as;
        logic ds;
        logic rw;
        logic pf;
        logic rstn;
    } ctl_t;

    // Value every synchronizer stage takes in reset: deselected and inhibited
    localparam ctl_t CTL_IDLE = '{mode: 1'b1, cs_n: 1'b1, as: 1'b0, ds: 1'b0,
                                  rw: 1'b1, pf: 1'b1, rstn: 1'b0};

    typedef enum logic [1:0] {PH_IDLE, PH_READ, PH_WRITE} phase_e;

    function automatic phase_e decode_phase(ctl_t c);
        phase_e p;
        p = PH_IDLE;
        if (c.mode) begin
            if (c.ds) p = c.rw ? PH_READ : PH_WRITE;
        end else begin
            if (!c.rw)     p = PH_WRITE;
            else if (!c.ds) p = PH_READ;
        end
        return p;
    endfunction

    function automatic logic qualified(ctl_t c);
        return !c.cs_n && !c.pf && c.rstn;
    endfunction

endpackage

// File: rtl/mbus_sync.sv
module mbus_sync
    import mbus_pkg::*;
#(
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          raw_ctl,
    input  logic [DW-1:0] raw_ad,
    output ctl_t          cur_ctl,
    output ctl_t          prv_ctl,
    output logic [DW-1:0] cur_ad
);
    localparam int LAST = STAGES - 1;

    ctl_t          ctl_st [STAGES+1];
    logic [DW-1:0] ad_st  [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_st[0] <= CTL_IDLE;
            ad_st[0]  <= '0;
        end else begin
            ctl_st[0] <= raw_ctl;
            ad_st[0]  <= raw_ad;
        end
    end

    // Remaining synchronizer stages plus one delayed copy for edge detection
    for (genvar k = 1; k <= STAGES; k++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) ctl_st[k] <= CTL_IDLE;
            else     ctl_st[k] <= ctl_st[k-1];
        end
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_ad
        always_ff @(posedge clk) begin
            if (rst) ad_st[k] <= '0;
            else     ad_st[k] <= ad_st[k-1];
        end
    end

    assign cur_ctl = ctl_st[LAST];
    assign prv_ctl = ctl_st[STAGES];
    assign cur_ad  = ad_st[LAST];
endmodule

// File: rtl/mbus_addr_latch.sv
module mbus_addr_latch
    import mbus_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          cur_ctl,
    input  ctl_t          prv_ctl,
    input  logic [DW-1:0] cur_ad,
    output logic [AW-1:0] addr_o
);
    logic as_fall;
    assign as_fall = prv_ctl.as && !cur_ctl.as;

    // Address capture ignores chip select and every inhibit
    always_ff @(posedge clk) begin
        if (rst)          addr_o <= '0;
        else if (as_fall) addr_o <= cur_ad[AW-1:0];
    end

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !as_fall |=> $stable(addr_o))
        else $error("R2: latched address moved without a strobe edge");
endmodule

// File: rtl/mbus_access_ctl.sv
module mbus_access_ctl
    import mbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_t          cur_ctl,
    input  ctl_t          prv_ctl,
    input  logic [DW-1:0] cur_ad,
    output logic          wr_o,
    output logic [DW-1:0] wdata_o,
    output logic          rd_o,
    output logic          oe_o
);
    phase_e ph_cur, ph_prv;
    logic   ok_q, ok_next, q_cur;

    always_comb begin
        ph_cur = decode_phase(cur_ctl);
        ph_prv = decode_phase(prv_ctl);
        q_cur  = qualified(cur_ctl);
        // ok tracks whether the phase has stayed qualified on every cycle so far
        ok_next = ok_q;
        if (ph_cur != PH_IDLE) begin
            if (ph_prv == PH_IDLE) ok_next = q_cur;
            else                   ok_next = ok_q && q_cur;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ok_q    <= 1'b0;
            wr_o    <= 1'b0;
            wdata_o <= '0;
            rd_o    <= 1'b0;
            oe_o    <= 1'b0;
        end else begin
            ok_q <= ok_next;
            wr_o <= (ph_prv == PH_WRITE) && (ph_cur != PH_WRITE) && ok_q;
            if (ph_cur == PH_WRITE) wdata_o <= cur_ad;
            rd_o <= (ph_cur == PH_READ) && (ph_prv != PH_READ) && q_cur;
            oe_o <= (ph_cur == PH_READ) && ok_next;
        end
    end

    a_r5_wr_single: assert property (@(posedge clk) disable iff (rst)
        wr_o |=> !wr_o)
        else $error("R5: write strobe wider than one clock");
    a_r6_rd_single: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> !rd_o)
        else $error("R6: read strobe wider than one clock");
    a_r6_rd_with_oe: assert property (@(posedge clk) disable iff (rst)
        rd_o |-> oe_o)
        else $error("R6: read strobe without output enable");
    a_r7_cs_drops_oe: assert property (@(posedge clk) disable iff (rst)
        cur_ctl.cs_n |=> !oe_o)
        else $error("R7: output enabled while deselected");
    a_r8_pf_blocks: assert property (@(posedge clk) disable iff (rst)
        cur_ctl.pf |=> !rd_o && !oe_o)
        else $error("R8: read during power fail");
    a_r9_rst_blocks: assert property (@(posedge clk) disable iff (rst)
        !cur_ctl.rstn |=> !rd_o && !oe_o)
        else $error("R9: read during host reset");
endmodule

// File: rtl/mbus_front.sv
module mbus_front
    import mbus_pkg::*;
#(
    parameter int AW          = 5,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_strap_i,
    input  logic          cs_n_i,
    input  logic          as_i,
    input  logic          ds_i,
    input  logic          rw_i,
    input  logic          pwr_fail_i,
    input  logic          host_rst_n_i,
    input  logic [DW-1:0] ad_i,
    output logic [DW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic          reg_wr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_rd_o,
    input  logic [DW-1:0] reg_rdata_i
);
    ctl_t          raw_ctl, cur_ctl, prv_ctl;
    logic [DW-1:0] cur_ad;

    assign raw_ctl = '{mode: mode_strap_i, cs_n: cs_n_i, as: as_i, ds: ds_i,
                       rw: rw_i, pf: pwr_fail_i, rstn: host_rst_n_i};

    mbus_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw_ctl(raw_ctl), .raw_ad(ad_i),
        .cur_ctl(cur_ctl), .prv_ctl(prv_ctl), .cur_ad(cur_ad)
    );

    mbus_addr_latch #(.AW(AW), .DW(DW)) u_addr (
        .clk(clk), .rst(rst), .cur_ctl(cur_ctl), .prv_ctl(prv_ctl),
        .cur_ad(cur_ad), .addr_o(reg_addr_o)
    );

    mbus_access_ctl #(.DW(DW)) u_acc (
        .clk(clk), .rst(rst), .cur_ctl(cur_ctl), .prv_ctl(prv_ctl),
        .cur_ad(cur_ad), .wr_o(reg_wr_o), .wdata_o(reg_wdata_o),
        .rd_o(reg_rd_o), .oe_o(ad_oe_o)
    );

    assign ad_o = ad_oe_o ? reg_rdata_i : '0;

    a_r6_bus_released: assert property (@(posedge clk) disable iff (rst)
        !ad_oe_o |-> (ad_o == '0))
        else $error("R6: bus driven while output disabled");
endmodule

// File: tb/mbus_front_tb.sv
module mbus_front_tb;
    localparam int AW = 6;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b1, cs_n = 1'b1, as_s = 1'b0, ds = 1'b0, rw = 1'b1;
    logic pf = 1'b0, hrstn = 1'b1;
    logic [DW-1:0] ad = '0;
    logic [DW-1:0] ad_o, wdata, rdata;
    logic [AW-1:0] addr;
    logic oe, wr, rd;

    always #5 clk = ~clk;

    assign rdata = {2'b10, addr} ^ 8'h5A;

    mbus_front #(.AW(AW), .DW(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .mode_strap_i(mode), .cs_n_i(cs_n), .as_i(as_s),
        .ds_i(ds), .rw_i(rw), .pwr_fail_i(pf), .host_rst_n_i(hrstn), .ad_i(ad),
        .ad_o(ad_o), .ad_oe_o(oe), .reg_addr_o(addr), .reg_wr_o(wr),
        .reg_wdata_o(wdata), .reg_rd_o(rd), .reg_rdata_i(rdata)
    );

    int checks = 0, errors = 0;
    bit finished = 0, cmp_en = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic mode, cs_n, as, ds, rw, pf, rstn;
        logic [7:0] ad;
    } smp_t;
    localparam smp_t SRST = '{mode:1'b1, cs_n:1'b1, as:1'b0, ds:1'b0, rw:1'b1,
                              pf:1'b1, rstn:1'b0, ad:8'h00};

    function automatic bit is_wr(smp_t s);   // R3 / R4 encodings
        return s.mode ? (s.ds && !s.rw) : !s.rw;
    endfunction
    function automatic bit is_rd(smp_t s);
        return s.mode ? (s.ds && s.rw) : (!s.ds && s.rw);
    endfunction
    function automatic bit good(smp_t s);    // R7 R8 R9
        return !s.cs_n && !s.pf && s.rstn;
    endfunction

    smp_t h1 = SRST, h2 = SRST, h3 = SRST, now_s, c, p;
    bit   m_ok = 0, e_wr = 0, e_rd = 0, e_oe = 0, ok_n;
    logic [7:0] m_wbuf = 0, e_wdata = 0;
    logic [AW-1:0] e_addr = 0;

    always @(posedge clk) begin
        now_s = '{mode:mode, cs_n:cs_n, as:as_s, ds:ds, rw:rw, pf:pf, rstn:hrstn, ad:ad};
        if (rst) begin
            h1 = SRST; h2 = SRST; h3 = SRST;
            m_ok = 0; e_wr = 0; e_rd = 0; e_oe = 0; m_wbuf = 0; e_wdata = 0; e_addr = 0;
        end else begin
            c = h2; p = h3;
            e_wr    = is_wr(p) && !is_wr(c) && m_ok;
            e_wdata = m_wbuf;
            if (is_wr(c)) m_wbuf = c.ad;
            ok_n = m_ok;
            if (is_wr(c) || is_rd(c)) ok_n = (is_wr(p) || is_rd(p)) ? (m_ok && good(c)) : good(c);
            e_rd = is_rd(c) && !is_rd(p) && good(c);
            e_oe = is_rd(c) && ok_n;
            m_ok = ok_n;
            if (p.as && !c.as) e_addr = c.ad[AW-1:0];
            h3 = h2; h2 = h1; h1 = now_s;
        end
    end

    int wr_cnt = 0, rd_cnt = 0;
    logic [7:0] last_wdata = 0;

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk(addr == e_addr, "R2 addr", addr, e_addr);
            chk(wr == e_wr, "R5 wr strobe", wr, e_wr);
            if (e_wr) chk(wdata == e_wdata, "R5 wdata", wdata, e_wdata);
            chk(rd == e_rd, "R6 rd strobe", rd, e_rd);
            chk(oe == e_oe, "R6 oe", oe, e_oe);
            chk(ad_o == (e_oe ? ({2'b10, e_addr} ^ 8'h5A) : 8'h00), "R6 ad_o", ad_o,
                e_oe ? ({2'b10, e_addr} ^ 8'h5A) : 8'h00);
            if (wr) begin wr_cnt++; last_wdata = wdata; end
            if (rd) rd_cnt++;
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle_for(input bit m);
        if (m) begin ds = 1'b0; rw = 1'b1; end else begin ds = 1'b1; rw = 1'b1; end
    endtask

    task automatic bus_cycle(input bit m, input bit csn, input logic [7:0] a,
                             input bit w, input logic [7:0] d, input bit pfv,
                             input bit hr, input bit glitch);
        mode = m; idle_for(m);
        pf = pfv; hrstn = hr; cs_n = csn;
        as_s = 1'b1; ad = a;
        repeat (2) @(negedge clk);
        as_s = 1'b0;
        repeat (2) @(negedge clk);
        if (w) ad = d;
        if (m) begin rw = !w; ds = 1'b1; end
        else if (w) rw = 1'b0;
        else ds = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cs_n = (glitch && i == 1) ? 1'b1 : csn;
            @(negedge clk);
        end
        idle_for(m);
        cs_n = 1'b1; pf = 1'b0; hrstn = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int w0, r0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(addr == 0 && !wr && !rd && !oe && ad_o == 0, "R1 in reset", {oe, rd, wr}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(addr == 0 && !wr && !rd && !oe && ad_o == 0, "R1 after release", {oe, rd, wr}, 0);
        cmp_en = 1;
        repeat (4) @(negedge clk);

        // R3 strobe-mode write, upper address bits dropped (R2)
        w0 = wr_cnt;
        bus_cycle(1, 0, 8'hEA, 1, 8'h5C, 0, 1, 0);
        chk(wr_cnt == w0 + 1, "R3 write count", wr_cnt - w0, 1);
        chk(last_wdata == 8'h5C, "R5 write data", last_wdata, 8'h5C);
        chk(addr == 6'h2A, "R2 truncated addr", addr, 6'h2A);

        // R3 strobe-mode read
        r0 = rd_cnt;
        bus_cycle(1, 0, 8'h13, 0, 8'h00, 0, 1, 0);
        chk(rd_cnt == r0 + 1, "R3 read count", rd_cnt - r0, 1);

        // R4 separate-strobe write and read
        w0 = wr_cnt; r0 = rd_cnt;
        bus_cycle(0, 0, 8'h07, 1, 8'hA3, 0, 1, 0);
        chk(wr_cnt == w0 + 1, "R4 write count", wr_cnt - w0, 1);
        chk(last_wdata == 8'hA3, "R4 write data", last_wdata, 8'hA3);
        bus_cycle(0, 0, 8'h3F, 0, 8'h00, 0, 1, 0);
        chk(rd_cnt == r0 + 1, "R4 read count", rd_cnt - r0, 1);

        // R7 deselected cycle: address still latched, no access
        w0 = wr_cnt;
        bus_cycle(1, 1, 8'h21, 1, 8'hFF, 0, 1, 0);
        chk(wr_cnt == w0, "R7 deselected write", wr_cnt - w0, 0);
        chk(addr == 6'h21, "R2 addr without cs", addr, 6'h21);
        // R7 chip select glitch in mid phase
        bus_cycle(0, 0, 8'h22, 1, 8'h11, 0, 1, 1);
        chk(wr_cnt == w0, "R7 glitch write", wr_cnt - w0, 0);
        chk(last_wdata == 8'hA3, "R7 data untouched", last_wdata, 8'hA3);

        // R8 power fail
        w0 = wr_cnt; r0 = rd_cnt;
        bus_cycle(1, 0, 8'h05, 1, 8'h77, 1, 1, 0);
        bus_cycle(0, 0, 8'h05, 0, 8'h00, 1, 1, 0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R8 power fail", (wr_cnt - w0) + (rd_cnt - r0), 0);
        // R9 host reset
        bus_cycle(0, 0, 8'h06, 1, 8'h88, 0, 0, 0);
        bus_cycle(1, 0, 8'h06, 0, 8'h00, 0, 0, 0);
        chk(wr_cnt == w0 && rd_cnt == r0, "R9 host reset", (wr_cnt - w0) + (rd_cnt - r0), 0);
        chk(addr == 6'h06, "R2 addr under reset", addr, 6'h06);

        // R10 latency of the address path
        mode = 1; idle_for(1);
        as_s = 1'b1; ad = 8'h19;
        repeat (4) @(negedge clk);
        as_s = 1'b0;
        repeat (2) @(negedge clk);
        chk(addr == 6'h06, "R10 not yet after two edges", addr, 6'h06);
        @(negedge clk);
        chk(addr == 6'h19, "R10 after third edge", addr, 6'h19);
        repeat (4) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule